// File: doc/BRIEF.md
# Timer-Clocked Asynchronous Serial Channel

This block is a full-duplex asynchronous serial channel. It sends and receives ten-bit frames: a low start bit, eight data bits with the least significant bit first, and a high stop bit. The block has no baud divider of its own. Its bit timing comes from overflow pulses that two external timers supply. Each direction has a select that picks which timer drives it. The first timer's pulses can be halved before the sixteen-tick bit counter, so a single doubling input sets the rate to the overflow rate over 16 or over 32.

Software starts a transmission by writing a byte to the transmit buffer. A completion flag rises when the stop bit has been sent. On the receive side, a falling edge on the line starts a frame. Every bit is decided by a majority vote of three samples taken near the middle of the bit. A complete frame is accepted only if reception is enabled and the previous byte has already been taken. The received stop bit is kept in its own status bit next to the byte. Each flag has a clear strobe.

Top module: `uart_tmr_chan`

## Requirements
- R1: After reset, `txd` is 1, `ti` and `ri` are 0, and `rd_data` and `stop_bit` are 0. `txd` stays 1 whenever no frame is being sent.
- R2: A transmitted frame is one 0 bit, then the eight bits of `wr_data` starting with bit 0, then one 1 bit, each for one bit period.
- R3: When a direction uses the first timer (its select is 0), its bit period is 16 `t1_ovf` pulses if `dbl` is 1 and 32 pulses if `dbl` is 0.
- R4: When a direction's select (`tx_sel2` or `rx_sel2`) is 1, its bit period is 16 `t2_ovf` pulses whatever the value of `dbl`. The two selects are independent.
- R5: A `wr_stb` pulse while the transmitter is idle starts a frame on the next clock. A `wr_stb` that arrives while a frame is in progress is ignored.
- R6: `ti` becomes 1 on the clock after the stop bit period ends. `ti_clr` clears it, and a completing frame wins over a clear in the same cycle.
- R7: The receiver starts on a 1-to-0 transition of `rxd`. Each bit value is the majority of three samples taken at ticks 7, 8 and 9 of the sixteen ticks in the bit, so a one-cycle glitch inside a bit does not change the received value.
- R8: If the start bit votes 1 at mid-bit, the receiver drops the frame, goes back to idle and waits for the next falling edge.
- R9: When a frame is accepted, the voted value of its stop bit is written to `stop_bit`. A stop bit of 0 is stored as 0 and the frame is still accepted.
- R10: At the end of a frame, `rd_data`, `stop_bit` and `ri` are updated only if `rx_en` is 1 and `ri` is 0. Otherwise the frame is discarded and all three keep their values. `ri_clr` clears `ri`. While `rx_en` is 0, no new frame starts.
- R11: Transmission and reception run at the same time without affecting each other, and each uses its own tick source.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| t1_ovf | input | 1 | One-cycle overflow pulse from the first timer |
| t2_ovf | input | 1 | One-cycle overflow pulse from the second timer |
| dbl | input | 1 | 1: first-timer rate /16; 0: /32 |
| tx_sel2 | input | 1 | Transmit bit clock from the second timer |
| rx_sel2 | input | 1 | Receive bit clock from the second timer |
| rx_en | input | 1 | Receive enable |
| wr_stb | input | 1 | Transmit buffer write strobe |
| wr_data | input | 8 | Byte to transmit |
| ti_clr | input | 1 | Clear the transmit-done flag |
| ri_clr | input | 1 | Clear the receive-done flag |
| rxd | input | 1 | Serial input line |
| txd | output | 1 | Serial output line |
| rd_data | output | 8 | Last accepted received byte |
| stop_bit | output | 1 | Stop bit of the last accepted frame |
| ti | output | 1 | Transmit-done flag |
| ri | output | 1 | Receive-done flag |

## Verification
Some rules are checked on every cycle by the assertions. A finishing transmit frame always sets `ti`, and the line is high when it does. A clear with no completion drops `ti`. `ri` only rises while reception is enabled. The received byte and stop bit never change while `ri` is held. Other behaviour can only be shown by the bench scenarios, because it depends on how bits line up over time: frame order, the 16/32 and second-timer bit periods, rejecting a false start, the majority vote masking a glitch, a write during a busy frame being ignored, and both directions running at once.

// File: rtl/uart_tmr_pkg.sv
package uart_tmr_pkg;

    // Receiver activity phase
    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } rx_phase_e;

    // Two-of-three majority
    function automatic logic vote3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

endpackage

// File: rtl/uart_baud_mux.sv
module uart_baud_mux (
    input  logic clk,
    input  logic rst_n,
    input  logic t1_ovf,
    input  logic t2_ovf,
    input  logic dbl,
    input  logic tx_sel2,
    input  logic rx_sel2,
    output logic tx_tick,
    output logic rx_tick
);
    localparam int N_DIR = 2;

    typedef struct packed {
        logic half;
    } div_t;

    div_t div_q, div_d;
    logic t1_rate;
    logic [N_DIR-1:0] dir_sel;
    logic [N_DIR-1:0] dir_tick;

    always_comb begin
        div_d = div_q;
        if (t1_ovf) begin
            div_d.half = ~div_q.half;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
        end else begin
            div_q <= div_d;
        end
    end

    // Halving passes every second first-timer pulse unless doubling is on
    assign t1_rate = t1_ovf & (dbl | div_q.half);
    assign dir_sel = {rx_sel2, tx_sel2};

    for (genvar g = 0; g < N_DIR; g++) begin : g_dir
        assign dir_tick[g] = dir_sel[g] ? t2_ovf : t1_rate;
    end

    assign tx_tick = dir_tick[0];
    assign rx_tick = dir_tick[1];
endmodule

// File: rtl/uart_tx_eng.sv
module uart_tx_eng #(
    parameter int DATA_W = 8,
    parameter int OVS    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              start,
    input  logic [DATA_W-1:0] data,
    output logic              txd,
    output logic              done
);
    localparam int FRAME_W = DATA_W + 2;
    localparam int CNT_W   = $clog2(OVS);
    localparam int BIT_W   = $clog2(FRAME_W + 1);

    typedef struct packed {
        logic               busy;
        logic [FRAME_W-1:0] sh;
        logic [CNT_W-1:0]   cnt;
        logic [BIT_W-1:0]   idx;
    } tx_st_t;

    tx_st_t q, d;

    always_comb begin
        d    = q;
        done = 1'b0;
        if (!q.busy) begin
            if (start) begin
                d.busy = 1'b1;
                d.sh   = {1'b1, data, 1'b0};
                d.cnt  = '0;
                d.idx  = '0;
            end
        end else if (tick) begin
            if (q.cnt == CNT_W'(OVS - 1)) begin
                d.cnt = '0;
                d.sh  = {1'b1, q.sh[FRAME_W-1:1]};
                if (q.idx == BIT_W'(FRAME_W - 1)) begin
                    d.busy = 1'b0;
                    done   = 1'b1;
                end else begin
                    d.idx = q.idx + 1'b1;
                end
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.busy <= 1'b0;
            q.sh   <= '1;
            q.cnt  <= '0;
            q.idx  <= '0;
        end else begin
            q <= d;
        end
    end

    assign txd = q.sh[0];
endmodule

// File: rtl/uart_rx_eng.sv
module uart_rx_eng
    import uart_tmr_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OVS    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              rxd,
    input  logic              rx_en,
    input  logic              ri,
    output logic              load,
    output logic [DATA_W-1:0] data,
    output logic              stop
);
    localparam int FRAME_W = DATA_W + 2;
    localparam int CNT_W   = $clog2(OVS);
    localparam int BIT_W   = $clog2(FRAME_W + 1);
    localparam int SMP_B   = OVS / 2;
    localparam int SMP_A   = SMP_B - 1;
    localparam int SMP_C   = SMP_B + 1;

    typedef struct packed {
        logic              s1;
        logic              s2;
        logic              prev;
        rx_phase_e         phase;
        logic [CNT_W-1:0]  cnt;
        logic [BIT_W-1:0]  idx;
        logic [1:0]        v;
        logic [DATA_W-1:0] sh;
    } rx_st_t;

    rx_st_t q, d;
    logic   bitv;

    always_comb begin
        d      = q;
        d.s1   = rxd;
        d.s2   = q.s1;
        d.prev = q.s2;
        load   = 1'b0;
        stop   = 1'b0;
        bitv   = vote3(q.v[0], q.v[1], q.s2);
        data   = q.sh;
        case (q.phase)
            PH_IDLE: begin
                if (rx_en && q.prev && !q.s2) begin
                    d.phase = PH_RUN;
                    d.cnt   = '0;
                    d.idx   = '0;
                end
            end
            default: begin
                if (tick) begin
                    if (q.cnt == CNT_W'(OVS - 1)) begin
                        d.cnt = '0;
                        d.idx = q.idx + 1'b1;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                    if (q.cnt == CNT_W'(SMP_A)) d.v[0] = q.s2;
                    if (q.cnt == CNT_W'(SMP_B)) d.v[1] = q.s2;
                    if (q.cnt == CNT_W'(SMP_C)) begin
                        if (q.idx == '0) begin
                            if (bitv) d.phase = PH_IDLE;
                        end else if (q.idx == BIT_W'(FRAME_W - 1)) begin
                            d.phase = PH_IDLE;
                            stop    = bitv;
                            load    = rx_en & ~ri;
                        end else begin
                            d.sh = {bitv, q.sh[DATA_W-1:1]};
                        end
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.s1    <= 1'b1;
            q.s2    <= 1'b1;
            q.prev  <= 1'b1;
            q.phase <= PH_IDLE;
            q.cnt   <= '0;
            q.idx   <= '0;
            q.v     <= '0;
            q.sh    <= '0;
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/uart_tmr_chan.sv
module uart_tmr_chan #(
    parameter int DATA_W = 8,
    parameter int OVS    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              t1_ovf,
    input  logic              t2_ovf,
    input  logic              dbl,
    input  logic              tx_sel2,
    input  logic              rx_sel2,
    input  logic              rx_en,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              ti_clr,
    input  logic              ri_clr,
    input  logic              rxd,
    output logic              txd,
    output logic [DATA_W-1:0] rd_data,
    output logic              stop_bit,
    output logic              ti,
    output logic              ri
);
    typedef struct packed {
        logic              ti;
        logic              ri;
        logic              stopb;
        logic [DATA_W-1:0] rbuf;
    } flag_t;

    flag_t f_q, f_d;

    logic              tx_tick, rx_tick;
    logic              tx_done, rx_load, rx_stop;
    logic [DATA_W-1:0] rx_byte;

    uart_baud_mux u_baud (
        .clk     (clk),
        .rst_n   (rst_n),
        .t1_ovf  (t1_ovf),
        .t2_ovf  (t2_ovf),
        .dbl     (dbl),
        .tx_sel2 (tx_sel2),
        .rx_sel2 (rx_sel2),
        .tx_tick (tx_tick),
        .rx_tick (rx_tick)
    );

    uart_tx_eng #(.DATA_W(DATA_W), .OVS(OVS)) u_tx (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tx_tick),
        .start (wr_stb),
        .data  (wr_data),
        .txd   (txd),
        .done  (tx_done)
    );

    uart_rx_eng #(.DATA_W(DATA_W), .OVS(OVS)) u_rx (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (rx_tick),
        .rxd   (rxd),
        .rx_en (rx_en),
        .ri    (f_q.ri),
        .load  (rx_load),
        .data  (rx_byte),
        .stop  (rx_stop)
    );

    always_comb begin
        f_d = f_q;
        if (tx_done) begin
            f_d.ti = 1'b1;
        end else if (ti_clr) begin
            f_d.ti = 1'b0;
        end
        if (rx_load) begin
            f_d.ri    = 1'b1;
            f_d.rbuf  = rx_byte;
            f_d.stopb = rx_stop;
        end else if (ri_clr) begin
            f_d.ri = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            f_q <= '0;
        end else begin
            f_q <= f_d;
        end
    end

    assign ti       = f_q.ti;
    assign ri       = f_q.ri;
    assign stop_bit = f_q.stopb;
    assign rd_data  = f_q.rbuf;
endmodule

// File: rtl/uart_tmr_chan_chk.sv
module uart_tmr_chan_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rx_en,
    input logic              ti_clr,
    input logic              txd,
    input logic              ti,
    input logic              ri,
    input logic              stop_bit,
    input logic [DATA_W-1:0] rd_data,
    input logic              tx_done
);
    // R6
    ti_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done |=> ti);

    // R6
    ti_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ti_clr && !tx_done) |=> !ti);

    // R1
    line_high_at_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ti) |-> txd);

    // R10
    ri_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ri) |-> $past(rx_en));

    // R10
    rbuf_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ri) |-> ($stable(rd_data) && $stable(stop_bit)));
endmodule

bind uart_tmr_chan uart_tmr_chan_chk #(.DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rx_en    (rx_en),
    .ti_clr   (ti_clr),
    .txd      (txd),
    .ti       (ti),
    .ri       (ri),
    .stop_bit (stop_bit),
    .rd_data  (rd_data),
    .tx_done  (tx_done)
);

// File: tb/uart_tmr_chan_test.sv
`timescale 1ns/1ps
module uart_tmr_chan_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       t1_ovf = 1'b1;
    logic       t2_ovf = 1'b0;
    logic       dbl = 1'b1;
    logic       tx_sel2 = 1'b0;
    logic       rx_sel2 = 1'b0;
    logic       rx_en = 1'b0;
    logic       wr_stb = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       ti_clr = 1'b0;
    logic       ri_clr = 1'b0;
    logic       rxd = 1'b1;
    logic       txd, stop_bit, ti, ri;
    logic [7:0] rd_data;

    int checks = 0;
    int errors = 0;
    int t2_cnt = 0;

    always #4 clk = ~clk;

    uart_tmr_chan uut (
        .clk(clk), .rst_n(rst_n), .t1_ovf(t1_ovf), .t2_ovf(t2_ovf),
        .dbl(dbl), .tx_sel2(tx_sel2), .rx_sel2(rx_sel2), .rx_en(rx_en),
        .wr_stb(wr_stb), .wr_data(wr_data), .ti_clr(ti_clr), .ri_clr(ri_clr),
        .rxd(rxd), .txd(txd), .rd_data(rd_data), .stop_bit(stop_bit),
        .ti(ti), .ri(ri)
    );

    // Second timer overflows every third cycle
    always @(negedge clk) begin
        t2_cnt <= (t2_cnt == 2) ? 0 : t2_cnt + 1;
        t2_ovf <= (t2_cnt == 2);
    end

    // {data, dbl, tx_sel2, rx_sel2}
    localparam logic [10:0] VEC [6] = '{
        {8'hA5, 1'b1, 1'b0, 1'b0},
        {8'h3C, 1'b0, 1'b0, 1'b0},
        {8'h81, 1'b1, 1'b1, 1'b0},
        {8'h7E, 1'b0, 1'b0, 1'b1},
        {8'h00, 1'b0, 1'b1, 1'b1},
        {8'hD2, 1'b1, 1'b0, 1'b1}
    };

    function automatic int per_of(input logic sel2, input logic d);
        return sel2 ? 48 : (d ? 16 : 32);
    endfunction

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic finish_sim();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    task automatic send_rx(input logic [7:0] b, input logic stopv, input int per);
        logic [9:0] fr;
        fr = {stopv, b, 1'b0};
        @(negedge clk);
        for (int i = 0; i < 10; i++) begin
            rxd = fr[i];
            repeat (per) @(negedge clk);
        end
        rxd = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    // All-ones byte with a one-cycle low glitch inside data bit 3 (frame bit 4)
    task automatic send_rx_glitch();
        logic [9:0] fr;
        fr = {1'b1, 8'hFF, 1'b0};
        @(negedge clk);
        for (int i = 0; i < 10; i++) begin
            rxd = fr[i];
            if (i == 4) begin
                repeat (9) @(negedge clk);
                rxd = 1'b0;
                @(negedge clk);
                rxd = 1'b1;
                repeat (6) @(negedge clk);
            end else begin
                repeat (16) @(negedge clk);
            end
        end
        rxd = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    task automatic tx_capture(input logic [7:0] b, input int per, input logic extra,
                              output logic [9:0] got);
        @(negedge clk);
        wr_data = b;
        wr_stb  = 1'b1;
        @(negedge clk);
        wr_stb  = 1'b0;
        repeat (per / 2) @(negedge clk);
        for (int i = 0; i < 10; i++) begin
            got[i] = txd;
            if (i < 9) begin
                if (extra && i == 4) begin
                    wr_data = ~b;
                    wr_stb  = 1'b1;
                    @(negedge clk);
                    wr_stb  = 1'b0;
                    repeat (per - 1) @(negedge clk);
                end else begin
                    repeat (per) @(negedge clk);
                end
            end
        end
        repeat (per / 2 + 4) @(negedge clk);
    endtask

    task automatic clear_flags();
        @(negedge clk);
        ti_clr = 1'b1;
        ri_clr = 1'b1;
        @(negedge clk);
        ti_clr = 1'b0;
        ri_clr = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual %0h expected %0h", 1, 0);
        finish_sim();
    end

    initial begin
        logic [9:0] got;
        logic [7:0] bd;
        int ptx, prx;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(txd == 1'b1, "R1 txd", txd, 1);
        chk(ti == 1'b0 && ri == 1'b0, "R1 flags", {ti, ri}, 0);
        chk(rd_data == 8'h00 && stop_bit == 1'b0, "R1 rbuf", rd_data, 0);
        rx_en = 1'b1;

        // Table: R2 format, R3/R4 rates, R11 concurrent directions
        for (int v = 0; v < 6; v++) begin
            bd      = VEC[v][10:3];
            dbl     = VEC[v][2];
            tx_sel2 = VEC[v][1];
            rx_sel2 = VEC[v][0];
            ptx = per_of(tx_sel2, dbl);
            prx = per_of(rx_sel2, dbl);
            fork
                tx_capture(bd, ptx, 1'b0, got);
                send_rx(~bd, 1'b1, prx);
            join
            chk(got == {1'b1, bd, 1'b0}, "R2/R3/R4 tx frame", got, {1'b1, bd, 1'b0});
            chk(rd_data == ~bd && ri, "R7/R11 rx byte", rd_data, ~bd);
            chk(stop_bit == 1'b1, "R9 stop", stop_bit, 1);
            chk(ti == 1'b1, "R6 ti set", ti, 1);
            clear_flags();
            chk(ti == 1'b0 && ri == 1'b0, "R6/R10 clear", {ti, ri}, 0);
        end

        dbl = 1'b1; tx_sel2 = 1'b0; rx_sel2 = 1'b0;

        // R8 false start
        @(negedge clk);
        rxd = 1'b0;
        repeat (3) @(negedge clk);
        rxd = 1'b1;
        repeat (40) @(negedge clk);
        chk(ri == 1'b0, "R8 false start", ri, 0);
        send_rx(8'h5A, 1'b1, 16);
        chk(ri && rd_data == 8'h5A, "R8 recover", rd_data, 8'h5A);
        clear_flags();

        // R9 stop bit 0 is captured
        send_rx(8'h33, 1'b0, 16);
        chk(ri && rd_data == 8'h33, "R9 byte", rd_data, 8'h33);
        chk(stop_bit == 1'b0, "R9 stop zero", stop_bit, 0);

        // R10 ri already set: frame discarded
        send_rx(8'hC4, 1'b1, 16);
        chk(rd_data == 8'h33 && stop_bit == 1'b0, "R10 ri held", rd_data, 8'h33);
        chk(ri == 1'b1, "R10 ri stays", ri, 1);
        clear_flags();

        // R10 receive disabled
        rx_en = 1'b0;
        send_rx(8'h99, 1'b1, 16);
        chk(ri == 1'b0 && rd_data == 8'h33, "R10 disabled", rd_data, 8'h33);
        rx_en = 1'b1;

        // R7 majority vote masks a one-cycle glitch
        send_rx_glitch();
        chk(ri && rd_data == 8'hFF, "R7 glitch", rd_data, 8'hFF);
        clear_flags();

        // R5 write during a busy frame ignored
        tx_capture(8'h6C, 16, 1'b1, got);
        chk(got == {1'b1, 8'h6C, 1'b0}, "R5 busy write", got, {1'b1, 8'h6C, 1'b0});
        chk(ti == 1'b1, "R6 after busy", ti, 1);
        repeat (40) @(negedge clk);
        chk(txd == 1'b1, "R5 no second frame", txd, 1);

        // R6 completion wins over clear is covered by assertion; clear here
        clear_flags();
        chk(ti == 1'b0, "R6 cleared", ti, 0);

        finish_sim();
    end
endmodule